// File: doc/BRIEF.md
# Multi-Queue DMA Queue Register File

This block is the control register file for a DMA engine that runs several independent hardware queues. A simple 32-bit register bus (valid, write, address, write data, registered read data) addresses it. The decoder splits each address into a queue index and a byte offset inside that queue's region. The regions are a fixed stride of `1 << REGION_SHIFT` bytes (0x100 by default) and start at `QBASE`. Each queue holds 64-bit base addresses for its submission ring and its completion ring, the depths of both rings, the submission tail doorbell, the completion head pointer, an enable/abort/pause control word, a self-clearing queue reset, a state field, and a sticky interrupt status with a mask.

The data path receives each queue's configuration on flat per-queue buses. It also receives a one-cycle doorbell pulse, carrying the queue index and the new tail, whenever software writes the tail of an enabled queue. Each queue has a small two-state machine. State `QS_IDLE` (code 0) moves to `QS_RUN` (code 1) on the transition "start" when the queue is enabled, not paused and no reset is pending. `QS_RUN` returns to `QS_IDLE` on the transition "stop" when the queue is disabled, paused or being reset.

Top module: `dmaq_regfile`

## Requirements
- R1: Queue q's registers sit at byte address QBASE + q*0x100 + offset, and queues do not alias one another. The offsets are: 0x00/0x04 submission base low/high, 0x08 submission depth, 0x0C submission tail, 0x10/0x14 completion base low/high, 0x18 completion depth, 0x1C completion head, 0x20 control, 0x24 reset, 0x30 state, 0x40 interrupt status, 0x44 interrupt mask. A read returns its data on bus_rdata in the cycle after the request.
- R2: The submission and completion base registers each store 64 bits, as a low word and a high word, and drive q_sq_base / q_cq_base (queue q at bits q*64 +: 64).
- R3: A depth write is accepted only when the value is a power of two from 32 to 8192. Any other value leaves the register unchanged. Depths drive q_sq_depth / q_cq_depth (14 bits per queue).
- R4: A tail write stores the value ANDed with (submission depth - 1). If control bit 0 (enable) is set, db_valid is high for exactly the next cycle, with db_qid equal to the queue index and db_tail equal to the stored tail. A disabled queue stores the tail with no pulse.
- R5: A completion head write stores the value ANDed with (completion depth - 1) and drives q_cq_head (13 bits per queue).
- R6: Control word bits are 0 enable, 2 abort-on-error and 4 pause. They read back in place, and the other bits read 0. The abort bit drives q_abort.
- R7: Writing 1 to bit 0 at offset 0x24 sets a reset bit that reads 1 for exactly one cycle and then clears itself. As it clears, the queue's tail and head become 0 and enable and pause become 0. Abort-on-error is kept.
- R8: The state field (offset 0x30, bits 3:0) reads 1 (run) from the cycle after the queue becomes enabled, unpaused and not in reset. It reads 0 (idle) from the cycle after any of those conditions fails. q_run mirrors run.
- R9: Interrupt status bits 14:0 are set by the matching int_evt input bit, stay set, and are cleared by writing 1 to them. A set and a clear of the same bit in the same cycle leave the bit set. Mask bits 14:0: 1 masks. q_irq is high while any status bit has a 0 mask bit.
- R10: Reads of undefined offsets, or of addresses outside all queue regions, return 0. Writes to them change nothing.
- R11: After reset, every register reads 0 except the depths (32) and the interrupt mask (0x7FFF). The state is idle, and db_valid and q_irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, one cycle after a read |
| int_evt | input | NUM_Q*15 | Interrupt event pulses, 15 per queue |
| db_valid | output | 1 | One-cycle doorbell pulse |
| db_qid | output | 2 | Queue index of the doorbell |
| db_tail | output | 13 | New submission tail |
| q_sq_base | output | NUM_Q*64 | Submission ring base per queue |
| q_cq_base | output | NUM_Q*64 | Completion ring base per queue |
| q_sq_depth | output | NUM_Q*14 | Submission depth per queue |
| q_cq_depth | output | NUM_Q*14 | Completion depth per queue |
| q_cq_head | output | NUM_Q*13 | Completion head per queue |
| q_run | output | NUM_Q | Queue is in the run state |
| q_abort | output | NUM_Q | Abort-on-error enable per queue |
| q_irq | output | NUM_Q | Unmasked interrupt pending per queue |

## Verification
A stuck or lagging state machine shows at the ports within two cycles of a control write: the state field and q_run disagree with the enable and pause bits just written. A reset bit that does not clear itself reads 1 on a second back-to-back read of offset 0x24, and the tail and head reads show whether the cleanup ran. Decode faults show up as a value read back from the wrong queue, or as a nonzero read from a hole, on the very next read.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

    // byte offsets inside one queue region
    localparam int OFS_SQ_LO    = 'h00;
    localparam int OFS_SQ_HI    = 'h04;
    localparam int OFS_SQ_DEPTH = 'h08;
    localparam int OFS_SQ_TAIL  = 'h0C;
    localparam int OFS_CQ_LO    = 'h10;
    localparam int OFS_CQ_HI    = 'h14;
    localparam int OFS_CQ_DEPTH = 'h18;
    localparam int OFS_CQ_HEAD  = 'h1C;
    localparam int OFS_CTRL     = 'h20;
    localparam int OFS_QRESET   = 'h24;
    localparam int OFS_STATE    = 'h30;
    localparam int OFS_ISTAT    = 'h40;
    localparam int OFS_IMASK    = 'h44;

    // control word bit positions
    localparam int CTL_EN    = 0;
    localparam int CTL_ABORT = 2;
    localparam int CTL_PAUSE = 4;

    typedef enum logic [3:0] {
        QS_IDLE = 4'd0,
        QS_RUN  = 4'd1
    } qstate_e;

endpackage

// File: rtl/dmaq_addr_decode.sv
module dmaq_addr_decode #(
    parameter int          NUM_Q        = 4,
    parameter int          QID_W        = 2,
    parameter int          REGION_SHIFT = 8,
    parameter logic [31:0] QBASE        = 32'h0
) (
    input  logic [31:0]             addr,
    output logic                    hit,
    output logic [QID_W-1:0]        qid,
    output logic [REGION_SHIFT-1:0] off
);
    localparam logic [32:0] SPAN = 33'(NUM_Q) << REGION_SHIFT;

    logic [32:0] rel;

    always_comb begin
        rel = {1'b0, addr} - {1'b0, QBASE};
        hit = ({1'b0, addr} >= {1'b0, QBASE}) && (rel < SPAN);
        qid = rel[REGION_SHIFT +: QID_W];
        off = rel[REGION_SHIFT-1:0];
    end
endmodule

// File: rtl/dmaq_queue_regs.sv
module dmaq_queue_regs
    import dmaq_pkg::*;
#(
    parameter int OFF_W     = 8,
    parameter int PTR_W     = 13,
    parameter int DEPTH_W   = 14,
    parameter int INT_W     = 15,
    parameter int DEPTH_MIN = 32,
    parameter int DEPTH_MAX = 8192
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_wr,
    input  logic [OFF_W-1:0]   off,
    input  logic [31:0]        wdata,
    input  logic [INT_W-1:0]   int_evt,
    output logic [31:0]        rdata,
    output logic               db_req,
    output logic [PTR_W-1:0]   tail_new,
    output logic [63:0]        sq_base,
    output logic [63:0]        cq_base,
    output logic [DEPTH_W-1:0] sq_depth,
    output logic [DEPTH_W-1:0] cq_depth,
    output logic [PTR_W-1:0]   cq_head,
    output logic               run,
    output logic               abort,
    output logic               irq
);
    logic [63:0]        sq_base_q, cq_base_q;
    logic [DEPTH_W-1:0] sq_depth_q, cq_depth_q;
    logic [PTR_W-1:0]   sq_tail_q, cq_head_q, head_new;
    logic               en_q, abort_q, pause_q, rst_q;
    logic [INT_W-1:0]   istat_q, imask_q, w1c;
    qstate_e            state_q, st_nxt;

    function automatic logic depth_ok(input logic [31:0] v);
        return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0) &&
               (v >= 32'(DEPTH_MIN)) && (v <= 32'(DEPTH_MAX));
    endfunction

    always_comb begin
        tail_new = wdata[PTR_W-1:0] & PTR_W'(sq_depth_q - DEPTH_W'(1));
        head_new = wdata[PTR_W-1:0] & PTR_W'(cq_depth_q - DEPTH_W'(1));
        w1c      = (sel_wr && off == OFF_W'(OFS_ISTAT)) ? wdata[INT_W-1:0] : '0;
    end

    // register storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_base_q  <= '0;
            cq_base_q  <= '0;
            sq_depth_q <= DEPTH_W'(DEPTH_MIN);
            cq_depth_q <= DEPTH_W'(DEPTH_MIN);
            sq_tail_q  <= '0;
            cq_head_q  <= '0;
            en_q       <= 1'b0;
            abort_q    <= 1'b0;
            pause_q    <= 1'b0;
            rst_q      <= 1'b0;
            istat_q    <= '0;
            imask_q    <= '1;
        end else begin
            istat_q <= (istat_q & ~w1c) | int_evt;
            if (sel_wr) begin
                case (off)
                    OFF_W'(OFS_SQ_LO):    sq_base_q[31:0]  <= wdata;
                    OFF_W'(OFS_SQ_HI):    sq_base_q[63:32] <= wdata;
                    OFF_W'(OFS_CQ_LO):    cq_base_q[31:0]  <= wdata;
                    OFF_W'(OFS_CQ_HI):    cq_base_q[63:32] <= wdata;
                    OFF_W'(OFS_SQ_DEPTH): if (depth_ok(wdata)) sq_depth_q <= DEPTH_W'(wdata);
                    OFF_W'(OFS_CQ_DEPTH): if (depth_ok(wdata)) cq_depth_q <= DEPTH_W'(wdata);
                    OFF_W'(OFS_SQ_TAIL):  sq_tail_q <= tail_new;
                    OFF_W'(OFS_CQ_HEAD):  cq_head_q <= head_new;
                    OFF_W'(OFS_CTRL): begin
                        en_q    <= wdata[CTL_EN];
                        abort_q <= wdata[CTL_ABORT];
                        pause_q <= wdata[CTL_PAUSE];
                    end
                    OFF_W'(OFS_QRESET):   rst_q   <= wdata[0];
                    OFF_W'(OFS_IMASK):    imask_q <= wdata[INT_W-1:0];
                    default: ;
                endcase
            end
            if (rst_q) begin
                rst_q     <= 1'b0;
                sq_tail_q <= '0;
                cq_head_q <= '0;
                en_q      <= 1'b0;
                pause_q   <= 1'b0;
            end
        end
    end

    // state machine: next state
    always_comb begin
        st_nxt = state_q;
        unique case (state_q)
            QS_IDLE: if (en_q && !pause_q && !rst_q) st_nxt = QS_RUN;
            QS_RUN:  if (!en_q || pause_q || rst_q)  st_nxt = QS_IDLE;
            default: st_nxt = QS_IDLE;
        endcase
    end

    // state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= QS_IDLE;
        else        state_q <= st_nxt;
    end

    // outputs
    always_comb begin
        run      = (state_q == QS_RUN);
        abort    = abort_q;
        irq      = |(istat_q & ~imask_q);
        db_req   = sel_wr && (off == OFF_W'(OFS_SQ_TAIL)) && en_q;
        sq_base  = sq_base_q;
        cq_base  = cq_base_q;
        sq_depth = sq_depth_q;
        cq_depth = cq_depth_q;
        cq_head  = cq_head_q;
    end

    // read mux
    always_comb begin
        rdata = '0;
        case (off)
            OFF_W'(OFS_SQ_LO):    rdata = sq_base_q[31:0];
            OFF_W'(OFS_SQ_HI):    rdata = sq_base_q[63:32];
            OFF_W'(OFS_CQ_LO):    rdata = cq_base_q[31:0];
            OFF_W'(OFS_CQ_HI):    rdata = cq_base_q[63:32];
            OFF_W'(OFS_SQ_DEPTH): rdata = 32'(sq_depth_q);
            OFF_W'(OFS_CQ_DEPTH): rdata = 32'(cq_depth_q);
            OFF_W'(OFS_SQ_TAIL):  rdata = 32'(sq_tail_q);
            OFF_W'(OFS_CQ_HEAD):  rdata = 32'(cq_head_q);
            OFF_W'(OFS_CTRL): begin
                rdata[CTL_EN]    = en_q;
                rdata[CTL_ABORT] = abort_q;
                rdata[CTL_PAUSE] = pause_q;
            end
            OFF_W'(OFS_QRESET):   rdata[0] = rst_q;
            OFF_W'(OFS_STATE):    rdata[3:0] = state_q;
            OFF_W'(OFS_ISTAT):    rdata[INT_W-1:0] = istat_q;
            OFF_W'(OFS_IMASK):    rdata[INT_W-1:0] = imask_q;
            default: ;
        endcase
    end

    assert_rst_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |=> !rst_q);
    assert_rst_cleanup_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |=> (sq_tail_q == '0 && cq_head_q == '0 && !en_q && !pause_q));
    assert_state_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !pause_q && !rst_q) |=> state_q == QS_RUN);
    assert_state_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q || pause_q || rst_q) |=> state_q == QS_IDLE);
    assert_depth_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        depth_ok(32'(sq_depth_q)) && depth_ok(32'(cq_depth_q)));
endmodule

// File: rtl/dmaq_regfile.sv
module dmaq_regfile #(
    parameter int          NUM_Q        = 4,
    parameter int          REGION_SHIFT = 8,
    parameter logic [31:0] QBASE        = 32'h0,
    parameter int          INT_W        = 15,
    parameter int          DEPTH_MIN    = 32,
    parameter int          DEPTH_MAX    = 8192,
    localparam int         QID_W        = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int         PTR_W        = $clog2(DEPTH_MAX),
    localparam int         DEPTH_W      = PTR_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_valid,
    input  logic                     bus_write,
    input  logic [31:0]              bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [NUM_Q*INT_W-1:0]   int_evt,
    output logic                     db_valid,
    output logic [QID_W-1:0]         db_qid,
    output logic [PTR_W-1:0]         db_tail,
    output logic [NUM_Q*64-1:0]      q_sq_base,
    output logic [NUM_Q*64-1:0]      q_cq_base,
    output logic [NUM_Q*DEPTH_W-1:0] q_sq_depth,
    output logic [NUM_Q*DEPTH_W-1:0] q_cq_depth,
    output logic [NUM_Q*PTR_W-1:0]   q_cq_head,
    output logic [NUM_Q-1:0]         q_run,
    output logic [NUM_Q-1:0]         q_abort,
    output logic [NUM_Q-1:0]         q_irq
);
    localparam int OFF_W = REGION_SHIFT;

    logic                    dec_hit;
    logic [QID_W-1:0]        dec_qid;
    logic [OFF_W-1:0]        dec_off;
    logic [31:0]             q_rdata   [NUM_Q];
    logic [PTR_W-1:0]        q_tailnew [NUM_Q];
    logic [NUM_Q-1:0]        q_dbreq;
    logic [NUM_Q-1:0]        sel_wr;

    dmaq_addr_decode #(
        .NUM_Q(NUM_Q), .QID_W(QID_W), .REGION_SHIFT(REGION_SHIFT), .QBASE(QBASE)
    ) u_dec (
        .addr(bus_addr), .hit(dec_hit), .qid(dec_qid), .off(dec_off)
    );

    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
        assign sel_wr[i] = bus_valid && bus_write && dec_hit && (dec_qid == QID_W'(i));

        dmaq_queue_regs #(
            .OFF_W(OFF_W), .PTR_W(PTR_W), .DEPTH_W(DEPTH_W), .INT_W(INT_W),
            .DEPTH_MIN(DEPTH_MIN), .DEPTH_MAX(DEPTH_MAX)
        ) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_wr   (sel_wr[i]),
            .off      (dec_off),
            .wdata    (bus_wdata),
            .int_evt  (int_evt[i*INT_W +: INT_W]),
            .rdata    (q_rdata[i]),
            .db_req   (q_dbreq[i]),
            .tail_new (q_tailnew[i]),
            .sq_base  (q_sq_base[i*64 +: 64]),
            .cq_base  (q_cq_base[i*64 +: 64]),
            .sq_depth (q_sq_depth[i*DEPTH_W +: DEPTH_W]),
            .cq_depth (q_cq_depth[i*DEPTH_W +: DEPTH_W]),
            .cq_head  (q_cq_head[i*PTR_W +: PTR_W]),
            .run      (q_run[i]),
            .abort    (q_abort[i]),
            .irq      (q_irq[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            db_valid  <= 1'b0;
            db_qid    <= '0;
            db_tail   <= '0;
        end else begin
            db_valid <= |q_dbreq;
            if (|q_dbreq) begin
                db_qid  <= dec_qid;
                db_tail <= q_tailnew[dec_qid];
            end
            if (bus_valid && !bus_write)
                bus_rdata <= dec_hit ? q_rdata[dec_qid] : 32'd0;
        end
    end

    assert_db_from_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        db_valid |-> $past(bus_valid && bus_write));
    assert_hole_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !dec_hit) |=> bus_rdata == 32'd0);
endmodule

// File: tb/dmaq_regfile_tb_top.sv
module dmaq_regfile_tb_top;
    localparam int NQ = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_valid = 1'b0, bus_write = 1'b0;
    logic [31:0]     bus_addr = '0, bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NQ*15-1:0] int_evt = '0;
    logic            db_valid;
    logic [1:0]      db_qid;
    logic [12:0]     db_tail;
    logic [NQ*64-1:0] q_sq_base, q_cq_base;
    logic [NQ*14-1:0] q_sq_depth, q_cq_depth;
    logic [NQ*13-1:0] q_cq_head;
    logic [NQ-1:0]   q_run, q_abort, q_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    dmaq_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .int_evt(int_evt), .db_valid(db_valid), .db_qid(db_qid), .db_tail(db_tail),
        .q_sq_base(q_sq_base), .q_cq_base(q_cq_base), .q_sq_depth(q_sq_depth),
        .q_cq_depth(q_cq_depth), .q_cq_head(q_cq_head), .q_run(q_run),
        .q_abort(q_abort), .q_irq(q_irq)
    );

    function automatic logic [31:0] qa(input int q, input int ofs);
        return 32'(q * 256 + ofs);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // all bus tasks start and end at a falling edge
    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R11 db_valid", 64'(db_valid), 0);
        check("R11 q_run", 64'(q_run), 0);
        check("R11 q_irq", 64'(q_irq), 0);
        rd(qa(0, 'h08), d); check("R11 sq depth", 64'(d), 32);
        rd(qa(3, 'h18), d); check("R11 cq depth", 64'(d), 32);
        rd(qa(2, 'h44), d); check("R11 mask", 64'(d), 'h7FFF);
        rd(qa(1, 'h30), d); check("R11 state", 64'(d), 0);
        rd(qa(1, 'h20), d); check("R11 ctrl", 64'(d), 0);
    endtask

    task automatic t_base();
        logic [31:0] d;
        wr(qa(1, 'h00), 32'hDEADBEEF);
        wr(qa(1, 'h04), 32'h12345678);
        wr(qa(3, 'h10), 32'hCAFEF00D);
        wr(qa(3, 'h14), 32'h00000001);
        rd(qa(1, 'h00), d); check("R2 sq lo", 64'(d), 'hDEADBEEF);
        rd(qa(1, 'h04), d); check("R2 sq hi", 64'(d), 'h12345678);
        check("R2 q_sq_base q1", q_sq_base[64 +: 64], 64'h12345678DEADBEEF);
        check("R2 q_cq_base q3", q_cq_base[192 +: 64], 64'h00000001CAFEF00D);
        check("R1 no alias q0", q_sq_base[0 +: 64], 0);
        rd(qa(2, 'h00), d); check("R1 no alias q2", 64'(d), 0);
    endtask

    task automatic t_depth();
        logic [31:0] d;
        wr(qa(0, 'h08), 64);
        rd(qa(0, 'h08), d); check("R3 legal 64", 64'(d), 64);
        wr(qa(0, 'h08), 100);
        rd(qa(0, 'h08), d); check("R3 non-pow2 ignored", 64'(d), 64);
        wr(qa(0, 'h08), 16);
        rd(qa(0, 'h08), d); check("R3 below min ignored", 64'(d), 64);
        wr(qa(0, 'h08), 16384);
        rd(qa(0, 'h08), d); check("R3 above max ignored", 64'(d), 64);
        wr(qa(0, 'h08), 8192);
        check("R3 max accepted", 64'(q_sq_depth[0 +: 14]), 8192);
        wr(qa(0, 'h18), 128);
        check("R3 cq depth", 64'(q_cq_depth[0 +: 14]), 128);
    endtask

    task automatic t_tail_db();
        logic [31:0] d;
        wr(qa(2, 'h20), 1);
        wr(qa(2, 'h0C), 5);
        check("R4 db pulse", 64'(db_valid), 1);
        check("R4 db qid", 64'(db_qid), 2);
        check("R4 db tail", 64'(db_tail), 5);
        @(negedge clk);
        check("R4 db one cycle", 64'(db_valid), 0);
        wr(qa(2, 'h0C), 37);
        check("R4 db tail masked", 64'(db_tail), 5);
        rd(qa(2, 'h0C), d); check("R4 tail stored", 64'(d), 5);
        wr(qa(1, 'h0C), 3);
        check("R4 disabled no pulse", 64'(db_valid), 0);
        rd(qa(1, 'h0C), d); check("R4 disabled tail stored", 64'(d), 3);
    endtask

    task automatic t_head();
        logic [31:0] d;
        wr(qa(3, 'h1C), 40);
        rd(qa(3, 'h1C), d); check("R5 head masked", 64'(d), 8);
        check("R5 q_cq_head", 64'(q_cq_head[39 +: 13]), 8);
    endtask

    task automatic t_ctrl();
        logic [31:0] d;
        wr(qa(1, 'h20), 32'hFFFFFFFF);
        rd(qa(1, 'h20), d); check("R6 ctrl readback", 64'(d), 'h15);
        check("R6 abort out", 64'(q_abort[1]), 1);
        rd(qa(1, 'h30), d); check("R8 paused idle", 64'(d), 0);
        check("R8 paused q_run", 64'(q_run[1]), 0);
        wr(qa(1, 'h20), 5);
        @(negedge clk);
        check("R8 run q_run", 64'(q_run[1]), 1);
        rd(qa(1, 'h30), d); check("R8 run state", 64'(d), 1);
    endtask

    task automatic t_state();
        logic [31:0] d;
        rd(qa(2, 'h30), d); check("R8 q2 running", 64'(d), 1);
        wr(qa(2, 'h20), 'h11);
        @(negedge clk);
        rd(qa(2, 'h30), d); check("R8 pause stops", 64'(d), 0);
        wr(qa(2, 'h20), 'h01);
        @(negedge clk);
        rd(qa(2, 'h30), d); check("R8 unpause runs", 64'(d), 1);
        wr(qa(2, 'h20), 'h00);
        @(negedge clk);
        rd(qa(2, 'h30), d); check("R8 disable stops", 64'(d), 0);
    endtask

    task automatic t_qreset();
        logic [31:0] d;
        wr(qa(2, 'h20), 5);
        wr(qa(2, 'h1C), 7);
        wr(qa(2, 'h0C), 9);
        @(negedge clk);
        check("R7 running before", 64'(q_run[2]), 1);
        wr(qa(2, 'h24), 1);
        rd(qa(2, 'h24), d); check("R7 bit set one cycle", 64'(d), 1);
        rd(qa(2, 'h24), d); check("R7 bit self clears", 64'(d), 0);
        rd(qa(2, 'h0C), d); check("R7 tail cleared", 64'(d), 0);
        rd(qa(2, 'h1C), d); check("R7 head cleared", 64'(d), 0);
        rd(qa(2, 'h20), d); check("R7 ctrl abort kept", 64'(d), 4);
        rd(qa(2, 'h30), d); check("R7 state idle", 64'(d), 0);
        check("R7 q_run low", 64'(q_run[2]), 0);
    endtask

    task automatic t_int();
        logic [31:0] d;
        int_evt[3] = 1'b1;
        @(negedge clk);
        int_evt[3] = 1'b0;
        rd(qa(0, 'h40), d); check("R9 status sticky", 64'(d), 'h8);
        check("R9 masked irq", 64'(q_irq[0]), 0);
        wr(qa(0, 'h44), 'h7FF7);
        check("R9 unmasked irq", 64'(q_irq[0]), 1);
        wr(qa(0, 'h40), 'h8);
        check("R9 w1c irq", 64'(q_irq[0]), 0);
        rd(qa(0, 'h40), d); check("R9 w1c status", 64'(d), 0);
    endtask

    task automatic t_undef();
        logic [31:0] d;
        rd(qa(0, 'h28), d); check("R10 hole read", 64'(d), 0);
        wr(qa(0, 'h2C), 32'hFFFF);
        rd(qa(0, 'h2C), d); check("R10 hole write", 64'(d), 0);
        wr(32'h400, 32'hA5A5A5A5);
        rd(32'h400, d); check("R10 outside read", 64'(d), 0);
        rd(qa(0, 'h00), d); check("R10 outside no write", 64'(d), 0);
        check("R10 q0 base untouched", q_sq_base[0 +: 64], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_base();
        t_depth();
        t_tail_db();
        t_head();
        t_ctrl();
        t_state();
        t_qreset();
        t_int();
        t_undef();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule